// File: doc/BRIEF.md
# Filtered Input Capture Unit

This block stamps external events with the value of a free-running 16-bit counter that another block supplies. An event arrives either on a pin or on a comparator output, chosen by a select input. The chosen signal passes a two-flop synchronizer, then an optional four-sample agreement filter clocked by the undivided system clock, then a rising-or-falling edge detector. When the detector sees the chosen edge, the counter value is copied into a 16-bit capture register, and the capture flag, which doubles as the interrupt request, goes high.

Software reaches the capture register over an 8-bit bus. A shared high-byte latch makes the 16-bit access atomic. Reading the low byte also freezes the high byte into the latch, and a later high-byte read returns that latch. When a mode input says the capture register is serving as the counter's TOP value, event detection is frozen. In that mode software may load the register: first the high byte into the latch, then the low byte, which commits all 16 bits.

The edge detector is a two-state machine. `LVL_LOW` and `LVL_HIGH` record the last level it accepted. It has three named transitions:
- RISE moves `LVL_LOW` to `LVL_HIGH` when a high level is seen.
- FALL moves `LVL_HIGH` to `LVL_LOW` when a low level is seen.
- HOLD keeps the state unchanged while TOP mode is active, or while the level has not moved.

A RISE strobes a capture when rising polarity is selected. A FALL strobes a capture when falling polarity is selected.

Top module: `evt_capture`

## Requirements
- R1: On a capture, the capture register takes the value `cnt_val` held just before the capturing clock edge, and `cap_irq` goes high at that same edge.
- R2: With `rise_sel`=1 only a low-to-high change of the selected input captures. With `rise_sel`=0 only a high-to-low change captures. The opposite change never captures.
- R3: With the filter off, a change of the input made between two rising edges is captured at the third following rising clock edge. With the filter on, it is captured at the seventh, which is four cycles later.
- R4: With the filter on, a new level held for four or more system cycles passes. A level held for three or fewer cycles produces no capture.
- R5: A read with `bus_hi`=0 returns bits 7:0 of the capture register and latches bits 15:8 into the temporary byte. A read with `bus_hi`=1 returns the temporary byte, even if a capture happened between the two reads.
- R6: `flag_clr` or `irq_ack` clears `cap_irq` at the next edge. If either of them coincides with a capture, the capture wins and the flag stays high.
- R7: A capture overwrites the register even when its previous value was never read.
- R8: While `icr_is_top`=1, no event captures and the flag does not rise. A write with `bus_hi`=1 loads the temporary byte. A write with `bus_hi`=0 commits {temporary byte, written byte} to the register. While `icr_is_top`=0, writes leave the register unchanged.
- R9: `src_cmp`=0 selects `pin_in` and `src_cmp`=1 selects `cmp_in`. The unselected input has no effect. Switching the source while the two inputs differ can produce a capture.
- R10: After reset, `cap_irq` is low and the capture register and temporary byte are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_in | input | 1 | External event pin |
| cmp_in | input | 1 | Comparator output event source |
| src_cmp | input | 1 | Source select: 0 pin, 1 comparator |
| filt_en | input | 1 | Enables the four-sample filter |
| rise_sel | input | 1 | Edge polarity: 1 rising, 0 falling |
| icr_is_top | input | 1 | Capture register serves as counter TOP |
| cnt_val | input | 16 | Counter value to be stamped |
| bus_hi | input | 1 | Byte select: 1 high, 0 low |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid while bus_rd is high |
| flag_clr | input | 1 | Software write-one-to-clear of the flag |
| irq_ack | input | 1 | Interrupt acknowledge, clears the flag |
| cap_irq | output | 1 | Capture flag and interrupt request |

## Verification
The bench checks the exact counter value captured at 2 and 6 steps past the stimulus. A design with an extra or missing register in the synchronizer or filter path would capture a neighbouring count. Pulses of three and four cycles probe the filter threshold, so a filter that counts one sample too few or too many fails on one side of it. A low-byte read is followed by a fresh capture before the high-byte read. A non-atomic latch would return the new high byte. The bench also lands a clear on the exact capture edge, where a design giving the clear priority would lose the event. It switches the source between differing inputs, freezes detection in TOP mode, and sends writes outside TOP mode that must be ignored.

// File: rtl/icap_pkg.sv
package icap_pkg;

    // Width of the CPU data bus; the capture register is two bus words.
    localparam int BUS_W = 8;
    localparam int CNT_W = 2 * BUS_W;

    // Last accepted level of the event input.
    typedef enum logic {
        LVL_LOW  = 1'b0,
        LVL_HIGH = 1'b1
    } lvl_state_t;

endpackage

// File: rtl/icap_sync.sv
module icap_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] sr;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr <= '0;
        end else begin
            sr <= {sr[STAGES-2:0], d};
        end
    end

    assign q = sr[STAGES-1];

endmodule

// File: rtl/icap_filter.sv
module icap_filter #(
    parameter int SAMPLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    input  logic en,
    input  logic hold,
    output logic dout
);

    localparam int HIST = SAMPLES - 1;

    logic [HIST-1:0] hist;
    logic            filt_q;
    logic            agree;

    // The current sample plus HIST older ones must all match.
    assign agree = (din && (&hist)) || (!din && !(|hist));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist   <= '0;
            filt_q <= 1'b0;
        end else if (!hold) begin
            hist <= {hist[HIST-2:0], din};
            if (!en || agree) begin
                filt_q <= din;
            end
        end
    end

    assign dout = en ? filt_q : din;

    // R4: a filtered output change only follows a full run of agreeing samples
    p_filter_agree_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (en && $past(en) && !$past(hold) && (filt_q != $past(filt_q)))
        |-> (hist == {HIST{filt_q}}));

endmodule

// File: rtl/icap_edge_fsm.sv
module icap_edge_fsm
    import icap_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    input  logic rise_sel,
    input  logic hold,
    output logic strobe
);

    lvl_state_t state_q;
    lvl_state_t state_d;

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= LVL_LOW;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: RISE, FALL, otherwise HOLD.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LVL_LOW:  if (!hold && lvl)  state_d = LVL_HIGH;
            LVL_HIGH: if (!hold && !lvl) state_d = LVL_LOW;
            default:  state_d = LVL_LOW;
        endcase
    end

    // Outputs: a capture strobe on the selected transition.
    always_comb begin
        strobe = 1'b0;
        unique case (state_q)
            LVL_LOW:  strobe = !hold && lvl && rise_sel;
            LVL_HIGH: strobe = !hold && !lvl && !rise_sel;
            default:  strobe = 1'b0;
        endcase
    end

    // R2: a capture only comes with a transition in the selected direction
    p_dir_r2: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> (state_q == ($past(rise_sel) ? LVL_HIGH : LVL_LOW)));

endmodule

// File: rtl/evt_capture.sv
module evt_capture
    import icap_pkg::*;
#(
    parameter int SYNC_STAGES  = 2,
    parameter int FILT_SAMPLES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pin_in,
    input  logic             cmp_in,
    input  logic             src_cmp,
    input  logic             filt_en,
    input  logic             rise_sel,
    input  logic             icr_is_top,
    input  logic [CNT_W-1:0] cnt_val,
    input  logic             bus_hi,
    input  logic             bus_rd,
    input  logic             bus_wr,
    input  logic [BUS_W-1:0] bus_wdata,
    output logic [BUS_W-1:0] bus_rdata,
    input  logic             flag_clr,
    input  logic             irq_ack,
    output logic             cap_irq
);

    logic             raw_evt;
    logic             sync_evt;
    logic             filt_evt;
    logic             cap_strobe;
    logic [CNT_W-1:0] icr_q;
    logic [BUS_W-1:0] temp_q;
    logic             flag_q;

    // Source select sits ahead of the synchronizer, so a switch behaves as an input change.
    assign raw_evt = src_cmp ? cmp_in : pin_in;

    icap_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_evt),
        .q     (sync_evt)
    );

    icap_filter #(.SAMPLES(FILT_SAMPLES)) u_filter (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (sync_evt),
        .en    (filt_en),
        .hold  (icr_is_top),
        .dout  (filt_evt)
    );

    icap_edge_fsm u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .lvl      (filt_evt),
        .rise_sel (rise_sel),
        .hold     (icr_is_top),
        .strobe   (cap_strobe)
    );

    // Capture register, shared high-byte latch and flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            icr_q  <= '0;
            temp_q <= '0;
            flag_q <= 1'b0;
        end else begin
            if (cap_strobe) begin
                icr_q <= cnt_val;
            end else if (bus_wr && !bus_hi && icr_is_top) begin
                icr_q <= {temp_q, bus_wdata};
            end

            if (bus_rd && !bus_hi) begin
                temp_q <= icr_q[CNT_W-1:BUS_W];
            end else if (bus_wr && bus_hi) begin
                temp_q <= bus_wdata;
            end

            if (cap_strobe) begin
                flag_q <= 1'b1;
            end else if (flag_clr || irq_ack) begin
                flag_q <= 1'b0;
            end
        end
    end

    assign bus_rdata = bus_hi ? temp_q : icr_q[BUS_W-1:0];
    assign cap_irq   = flag_q;

    // R1: the counter value is stored on the capturing edge
    p_icr_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cap_strobe |=> (icr_q == $past(cnt_val)));

    // R1: the flag is high straight after a capture
    p_flag_set_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cap_strobe |=> cap_irq);

    // R5: a low-byte read freezes the high byte in the latch
    p_temp_latch_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_hi) |=> (temp_q == $past(icr_q[CNT_W-1:BUS_W])));

    // R6: a clear without a concurrent capture drops the flag
    p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((flag_clr || irq_ack) && !cap_strobe) |=> !cap_irq);

    // R8: in TOP mode only a low-byte write may change the register
    p_hold_top_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (icr_is_top && !(bus_wr && !bus_hi)) |=> $stable(icr_q));

endmodule

// File: tb/test_evt_capture.sv
module test_evt_capture;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pin_in = 1'b0;
    logic        cmp_in = 1'b0;
    logic        src_cmp = 1'b0;
    logic        filt_en = 1'b0;
    logic        rise_sel = 1'b1;
    logic        icr_is_top = 1'b0;
    logic [15:0] cnt_val;
    logic        bus_hi = 1'b0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_wdata = 8'h00;
    logic [7:0]  bus_rdata;
    logic        flag_clr = 1'b0;
    logic        irq_ack = 1'b0;
    logic        cap_irq;

    logic [15:0] step = 16'd1;
    int          checks = 0;
    int          failures = 0;
    bit          done = 1'b0;

    always #2ns clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n) cnt_val <= 16'd0;
        else        cnt_val <= cnt_val + step;
    end

    evt_capture i_evt_capture (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin_in     (pin_in),
        .cmp_in     (cmp_in),
        .src_cmp    (src_cmp),
        .filt_en    (filt_en),
        .rise_sel   (rise_sel),
        .icr_is_top (icr_is_top),
        .cnt_val    (cnt_val),
        .bus_hi     (bus_hi),
        .bus_rd     (bus_rd),
        .bus_wr     (bus_wr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .flag_clr   (flag_clr),
        .irq_ack    (irq_ack),
        .cap_irq    (cap_irq)
    );

    // rise, filter on, pulse length in cycles, capture expected
    typedef struct packed {
        logic       rise;
        logic       filt;
        logic [3:0] len;
        logic       hit;
    } vec_t;

    localparam vec_t VEC [8] = '{
        '{1'b1, 1'b0, 4'd2, 1'b1},
        '{1'b0, 1'b0, 4'd1, 1'b1},
        '{1'b1, 1'b1, 4'd4, 1'b1},
        '{1'b1, 1'b1, 4'd3, 1'b0},
        '{1'b0, 1'b1, 4'd5, 1'b1},
        '{1'b0, 1'b1, 4'd2, 1'b0},
        '{1'b1, 1'b0, 4'd1, 1'b1},
        '{1'b0, 1'b1, 4'd4, 1'b1}
    };

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic nclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rd_byte(input logic hi, output logic [7:0] v);
        bus_hi = hi;
        bus_rd = 1'b1;
        #1ns v = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic rd_icr(output logic [15:0] v);
        logic [7:0] lo;
        logic [7:0] hi;
        rd_byte(1'b0, lo);
        rd_byte(1'b1, hi);
        v = {hi, lo};
    endtask

    task automatic wr_byte(input logic hi, input logic [7:0] d);
        bus_hi = hi;
        bus_wdata = d;
        bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic clr_flag();
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [15:0] c;
        logic [15:0] e1;
        logic [15:0] e2;
        logic [15:0] v;
        logic [7:0]  b;

        nclk(3);
        rst_n = 1'b1;
        nclk(1);
        // R10: reset state
        chk("R10 flag", cap_irq, 0);
        rd_icr(v);
        chk("R10 icr", v, 16'h0000);

        // Vector table: R1 R2 R3 R4
        for (int i = 0; i < 8; i++) begin
            rise_sel = VEC[i].rise;
            filt_en  = VEC[i].filt;
            pin_in   = !VEC[i].rise;
            nclk(10);
            clr_flag();
            c = cnt_val;
            pin_in = VEC[i].rise;
            nclk(int'(VEC[i].len));
            pin_in = !VEC[i].rise;
            nclk(12);
            chk(VEC[i].hit ? "R1 R2 flag" : "R4 short pulse flag", cap_irq, VEC[i].hit);
            if (VEC[i].hit) begin
                rd_icr(v);
                chk("R3 captured count", v, c + (VEC[i].filt ? 16'd6 : 16'd2));
            end
        end

        // R6: clear on the capture edge loses to the capture
        rise_sel = 1'b1;
        filt_en = 1'b0;
        pin_in = 1'b0;
        nclk(10);
        clr_flag();
        c = cnt_val;
        pin_in = 1'b1;
        nclk(2);
        flag_clr = 1'b1;
        nclk(1);
        flag_clr = 1'b0;
        chk("R6 capture beats clear", cap_irq, 1);
        rd_icr(v);
        chk("R1 value", v, c + 16'd2);
        irq_ack = 1'b1;
        nclk(1);
        irq_ack = 1'b0;
        chk("R6 ack clears", cap_irq, 0);
        pin_in = 1'b0;
        nclk(6);
        pin_in = 1'b1;
        nclk(6);
        chk("R6 flag set again", cap_irq, 1);
        clr_flag();
        chk("R6 write-one clears", cap_irq, 0);

        // R5 and R7: atomic read across an overwriting capture
        pin_in = 1'b0;
        step = 16'h0101;
        nclk(6);
        c = cnt_val;
        pin_in = 1'b1;
        e1 = c + 16'h0202;
        nclk(6);
        rd_byte(1'b0, b);
        chk("R5 low byte", b, e1[7:0]);
        pin_in = 1'b0;
        nclk(6);
        c = cnt_val;
        pin_in = 1'b1;
        e2 = c + 16'h0202;
        nclk(6);
        rd_byte(1'b1, b);
        chk("R5 latched high byte", b, e1[15:8]);
        rd_icr(v);
        chk("R7 overwrite", v, e2);
        step = 16'd1;
        pin_in = 1'b0;
        nclk(6);
        clr_flag();

        // R8: TOP mode freezes detection and allows a two-step write
        icr_is_top = 1'b1;
        nclk(2);
        pin_in = 1'b1;
        nclk(4);
        pin_in = 1'b0;
        nclk(6);
        chk("R8 no flag in TOP mode", cap_irq, 0);
        rd_icr(v);
        chk("R8 no capture in TOP mode", v, e2);
        wr_byte(1'b1, 8'hAB);
        wr_byte(1'b0, 8'hCD);
        rd_icr(v);
        chk("R8 write commit", v, 16'hABCD);
        icr_is_top = 1'b0;
        nclk(6);
        wr_byte(1'b1, 8'h12);
        wr_byte(1'b0, 8'h34);
        rd_icr(v);
        chk("R8 write ignored", v, 16'hABCD);
        chk("R8 no stray flag", cap_irq, 0);

        // R9: comparator source
        src_cmp = 1'b1;
        cmp_in = 1'b0;
        nclk(6);
        clr_flag();
        pin_in = 1'b1;
        nclk(3);
        pin_in = 1'b0;
        nclk(6);
        chk("R9 pin ignored", cap_irq, 0);
        c = cnt_val;
        cmp_in = 1'b1;
        nclk(6);
        chk("R9 comparator flag", cap_irq, 1);
        rd_icr(v);
        chk("R9 comparator value", v, c + 16'd2);
        cmp_in = 1'b0;
        nclk(6);
        clr_flag();
        pin_in = 1'b1;
        nclk(6);
        chk("R9 unselected pin", cap_irq, 0);
        c = cnt_val;
        src_cmp = 1'b0;
        nclk(6);
        chk("R9 switch captures", cap_irq, 1);
        rd_icr(v);
        chk("R9 switch value", v, c + 16'd2);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule